// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt

This block is a reloadable down-counter that paces itself from one of four tick rates: 4.096 kHz, 64 Hz, 1 Hz and one tick per minute. A free-running prescaler derives all four rates from the fast system clock as single-cycle enables. The host writes a start value n. The counter then counts down on the chosen tick. At the end of each countdown it reloads n and sets a sticky expiry flag, so the timer keeps running periodically until it is reloaded.

The flag drives an active-low interrupt request. In level mode the request follows the flag until the host clears it. In pulse mode the request goes low for one 64 Hz period at each expiry. An enable bit masks the request without touching the flag. Reading the count address returns the live counter value, which keeps moving during the read.

The host port is a plain register port. A write takes effect at the clock edge where `wr_en` is high. A read is combinational on `rd_addr`. There are three addresses:
- Address 0 is control: bit 0 is the interrupt enable, bit 1 selects pulse mode, and bits 3:2 select the source.
- Address 1 is status, with the flag in bit 0.
- Address 2 takes n on a write and returns the live count on a read.

The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cd_timer`

## Requirements
- R1: Control bits 3:2 select the tick source: 0 = 4.096 kHz, 1 = 64 Hz, 2 = 1 Hz, 3 = 1/60 Hz. The four rates are FAST_DIV, FAST_DIV·MID_DIV, ·SLOW_DIV and ·MIN_DIV system cycles per tick.
- R2: The expiry flag (status bit 0) is set at the end of every countdown period and stays set.
- R3: A status write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R4: When the count expires, n is reloaded automatically. In steady state, one period is exactly n source ticks.
- R5: With the 4.096 kHz or 64 Hz source, the first source tick after a load only synchronises the counter. The first period therefore lasts more than n and at most n+1 ticks.
- R6: With the 1 Hz or 1/60 Hz source, the first decrement happens on the first 64 Hz tick after a load. The remaining n−1 decrements follow on source ticks, so the first period is at most (n−1) source periods plus one 64 Hz period.
- R7: In level mode (control bit 1 = 0) with the enable set, `irq_n` is low while the flag is set. It returns high in the cycle after the clearing write.
- R8: In pulse mode (control bit 1 = 1) with the enable set, `irq_n` goes low at each expiry for FAST_DIV·MID_DIV cycles, which is one 64 Hz period.
- R9: With control bit 0 = 0, `irq_n` stays high while the flag is still set by expiries.
- R10: A read of address 2 returns the live count. The count is never above n and decreases by one per source tick.
- R11: Writing n = 0 stops the timer. The count reads 0 and the flag is never set.
- R12: After reset, control, flag and count read 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the timer with FAST_DIV=4, MID_DIV=4, SLOW_DIV=4 and MIN_DIV=3. This gives a fast tick every 4 cycles, a 64 Hz tick every 16, a 1 Hz tick every 64 and a minute tick every 192. With these values, all four sources, both first-period rules and the steady reload period fit into a few thousand cycles. The 16-cycle interrupt pulse stays shorter than the measured periods, so consecutive pulses can be told apart. The first-period bounds are checked against the tick grid these ratios imply, and the steady periods are checked for exact cycle counts.

// File: rtl/cd_timer_pkg.sv
package cd_timer_pkg;
  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_MIN  = 2'd3
  } src_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
endpackage

// File: rtl/cd_timer_prescale.sv
module cd_timer_prescale #(
  parameter int unsigned FAST_DIV = 24414,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned MIN_DIV  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] tick
);
  function automatic int unsigned div_of(input int idx);
    case (idx)
      0:       return FAST_DIV;
      1:       return MID_DIV;
      2:       return SLOW_DIV;
      default: return MIN_DIV;
    endcase
  endfunction

  logic [3:0] wrap;
  logic [3:0] adv;

  always_comb begin
    tick[0] = wrap[0];
    for (int i = 1; i < 4; i++) tick[i] = tick[i-1] & wrap[i];
  end

  assign adv = {tick[2:0], 1'b1};

  for (genvar g = 0; g < 4; g++) begin : g_stage
    localparam int unsigned D = div_of(g);
    localparam int W = (D > 1) ? $clog2(D) : 1;
    logic [W-1:0] cnt;

    assign wrap[g] = (cnt == W'(D - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (adv[g])   cnt <= wrap[g] ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cd_timer_count.sv
module cd_timer_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         src_tick,
  input  logic         tick64,
  input  logic         slow_src,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         expire
);
  logic armed;
  logic step;
  logic arm_evt;
  logic last;
  logic running;

  assign running = (reload != '0);
  assign arm_evt = !armed && (slow_src ? tick64 : src_tick);
  // fast sources: the synchronising tick does not count
  // slow sources: the first 64 Hz tick already counts
  assign step    = slow_src ? ((!armed && tick64) || (armed && src_tick))
                            : (armed && src_tick);
  assign last    = (count <= W'(1));
  assign expire  = running && step && last && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      armed  <= 1'b0;
    end else if (load) begin
      reload <= load_val;
      count  <= load_val;
      armed  <= 1'b0;
    end else if (running) begin
      if (arm_evt) armed <= 1'b1;
      if (step)    count <= last ? reload : count - 1'b1;
    end
  end
endmodule

// File: rtl/cd_timer_irq.sv
module cd_timer_irq #(
  parameter int unsigned PULSE_CYC = 1562496
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic irq_en,
  input  logic pulse_mode,
  output logic flag,
  output logic irq_n
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (expire)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_cnt <= '0;
    else if (expire)            pulse_cnt <= PW'(PULSE_CYC);
    else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign irq_n = !(irq_en && (pulse_mode ? (pulse_cnt != '0) : flag));
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cd_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FAST_DIV = 24414,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned MIN_DIV  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int unsigned PULSE_CYC = FAST_DIV * MID_DIV;

  logic        irq_en;
  logic        pulse_mode;
  src_e        src;
  logic [3:0]  tick;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] reload;
  logic        expire;
  logic        flag;
  logic        load;
  logic        clr_req;
  logic        slow_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en     <= 1'b0;
      pulse_mode <= 1'b0;
      src        <= SRC_FAST;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      irq_en     <= wr_data[0];
      pulse_mode <= wr_data[1];
      src        <= src_e'(wr_data[3:2]);
    end
  end

  assign load     = wr_en && (wr_addr == ADDR_COUNT);
  assign clr_req  = wr_en && (wr_addr == ADDR_STAT) && !wr_data[0];
  assign slow_src = (src == SRC_SEC) || (src == SRC_MIN);

  cd_timer_prescale #(
    .FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV),
    .SLOW_DIV(SLOW_DIV), .MIN_DIV(MIN_DIV)
  ) i_prescale (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cd_timer_count #(.W(DATA_W)) i_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data),
    .src_tick(tick[src]), .tick64(tick[1]), .slow_src(slow_src),
    .count(count), .reload(reload), .expire(expire)
  );

  cd_timer_irq #(.PULSE_CYC(PULSE_CYC)) i_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
    .irq_en(irq_en), .pulse_mode(pulse_mode), .flag(flag), .irq_n(irq_n)
  );

  always_comb begin
    case (rd_addr)
      ADDR_CTRL:  rd_data = DATA_W'({src, pulse_mode, irq_en});
      ADDR_STAT:  rd_data = DATA_W'(flag);
      ADDR_COUNT: rd_data = count;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         flag,
  input logic         expire,
  input logic [W-1:0] count,
  input logic [W-1:0] reload
);
  // R3
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && wr_addr == 2'd1 && !wr_data[0]));

  // R2
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !(wr_en && wr_addr == 2'd2)) |=> (count == $past(reload)));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= reload);

  // R11
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0) |-> !expire);
endmodule

bind cd_timer cd_timer_chk #(.W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .flag(flag), .expire(expire),
  .count(count), .reload(reload)
);

// File: tb/test_cd_timer.sv
module test_cd_timer;
  localparam int DW = 8;
  localparam int FD = 4, MD = 4, SD = 4, ND = 3;
  localparam int T_FAST = FD;
  localparam int T_MID  = FD * MD;
  localparam int T_SEC  = T_MID * SD;
  localparam int T_MIN  = T_SEC * ND;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cd_timer #(.DATA_W(DW), .FAST_DIV(FD), .MID_DIV(MD), .SLOW_DIV(SD), .MIN_DIV(ND))
    i_cd_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, commit at posedge, return on the following negedge
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // negedges until irq_n goes high-to-low; -1 on timeout
  task automatic wait_fall(input int max, output int n);
    logic prev = irq_n;
    n = -1;
    for (int k = 1; k <= max; k++) begin
      @(negedge clk);
      if (prev && !irq_n) begin n = k; break; end
      prev = irq_n;
    end
  endtask

  task automatic wait_flag(input int max, output int n);
    int v;
    n = -1;
    for (int k = 1; k <= max; k++) begin
      @(negedge clk);
      rd(2'd1, v);
      if (v[0]) begin n = k; break; end
    end
  endtask

  task automatic t_reset;
    int v;
    rd(2'd0, v); check(v == 0, "R12 ctrl", v, 0);
    rd(2'd1, v); check(v == 0, "R12 flag", v, 0);
    rd(2'd2, v); check(v == 0, "R12 count", v, 0);
    check(irq_n == 1'b1, "R12 irq_n", irq_n, 1);
  endtask

  task automatic t_fast_pulse;
    int d, p, w;
    wr(2'd0, 8'h03);          // enable, pulse mode, source 0
    wr(2'd2, 8'd8);
    d = 1;
    while (irq_n && d < 100) begin @(negedge clk); d++; end
    check(d > 8 * T_FAST && d <= 9 * T_FAST, "R5 first period", d, 9 * T_FAST);
    w = 0;
    while (!irq_n && w < 100) begin w++; @(negedge clk); end
    check(w == T_MID, "R8 pulse width", w, T_MID);
    wait_fall(200, p);
    check(p == 8 * T_FAST - w, "R4 R1 fast steady period", p + w, 8 * T_FAST);
  endtask

  task automatic t_level;
    int n, v;
    wr(2'd0, 8'h05);          // enable, level mode, source 1
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd2);
    wait_flag(100, n);
    check(n > 0, "R2 flag set", n, 1);
    check(irq_n == 1'b0, "R7 level low", irq_n, 0);
    wr(2'd1, 8'h01);
    rd(2'd1, v);
    check(v == 1, "R3 write one keeps flag", v, 1);
    check(irq_n == 1'b0, "R7 still low", irq_n, 0);
    wr(2'd1, 8'h00);
    check(irq_n == 1'b1, "R7 release after clear", irq_n, 1);
    rd(2'd1, v);
    check(v == 0, "R3 write zero clears", v, 0);
    wait_flag(100, n);
    check(n > 0 && n <= 2 * T_MID + 1, "R4 R2 flag sets again", n, 2 * T_MID);
  endtask

  task automatic t_mask;
    int v;
    bit seen_low = 1'b0;
    wr(2'd0, 8'h00);          // disabled, level, source 0
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd2);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!irq_n) seen_low = 1'b1;
    end
    check(!seen_low, "R9 irq masked", seen_low, 0);
    rd(2'd1, v);
    check(v == 1, "R9 flag still set", v, 1);
  endtask

  task automatic t_live;
    int a, b;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd200);
    repeat (20) @(negedge clk);
    rd(2'd2, a);
    check(a < 200 && a >= 194, "R10 live count moved", a, 195);
    repeat (40) @(negedge clk);
    rd(2'd2, b);
    check(b == a - 10, "R10 one per tick", b, a - 10);
  endtask

  task automatic t_zero;
    int v;
    wr(2'd0, 8'h01);
    wr(2'd2, 8'd0);
    wr(2'd1, 8'h00);
    repeat (300) @(negedge clk);
    rd(2'd1, v); check(v == 0, "R11 no flag", v, 0);
    rd(2'd2, v); check(v == 0, "R11 count zero", v, 0);
    check(irq_n == 1'b1, "R11 irq idle", irq_n, 1);
  endtask

  task automatic t_slow;
    int d, p;
    wr(2'd0, 8'h0B);          // enable, pulse, source 2
    wr(2'd2, 8'd3);
    d = 1;
    while (irq_n && d < 400) begin @(negedge clk); d++; end
    check(d >= 1 + T_MID + T_SEC && d <= T_MID + 2 * T_SEC, "R6 first period", d, T_MID + 2 * T_SEC);
    wait_fall(400, p);
    check(p == 3 * T_SEC, "R4 R1 second source period", p, 3 * T_SEC);
    wr(2'd0, 8'h0F);          // source 3
    wr(2'd2, 8'd2);
    wait_fall(1000, p);
    check(p > 0 && p <= T_MID + T_MIN + 1, "R6 minute first period", p, T_MID + T_MIN);
    wait_fall(1000, p);
    check(p == 2 * T_MIN, "R4 R1 minute source period", p, 2 * T_MIN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_pulse();
    t_level();
    t_mask();
    t_live();
    t_zero();
    t_slow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule